// File: doc/BRIEF.md
# Masked Chip-Select Address Decoder

This block sits on the internal bus ahead of an external memory controller. It decides which of several chip-select windows an access belongs to. Each window holds a base value for the upper address half and a per-bit don't-care mask for it. The mask register also carries a valid flag and a write-protect flag. A small register port writes and reads back these two words per window.

On every access strobe, each valid window compares the upper address bits that its mask does not exclude. If several windows match, the lowest-numbered one wins, and the block reports the result one clock later as a one-hot select, a binary window index, and exactly one of three outcomes:

- **hit**: the access selects a window.
- **miss**: no valid window matches.
- **bus error**: a write lands in a protected window. In this case no select is driven, so no external cycle can start.

Top module: `wsel_top`

## Requirements
- R1: After reset every configuration register reads zero, every window is invalid, all outputs are low, and any access reports a miss.
- R2: The base register (register select 0) keeps written bits 31:16 as the window base; bits 15:0 read back as zero whatever was written.
- R3: The mask register (register select 1) keeps bits 31:16 as the don't-care mask, bit 8 as write-protect and bit 0 as valid; every other bit reads back as zero.
- R4: An upper address bit whose mask bit is 0 must equal the base bit for a match; an upper address bit whose mask bit is 1 is ignored; address bits 15:0 never take part.
- R5: A window whose valid bit is 0 never matches, even when its base equals the address.
- R6: When several valid windows match, only the lowest-numbered one is selected.
- R7: An access that matches no valid window raises miss, with hit, bus error and every select low.
- R8: A write whose winning window is write-protected raises bus error with hit low and every select low.
- R9: A read whose winning window is write-protected completes as a normal hit.
- R10: Outputs change on the clock edge that samples the access strobe; in the cycle after an edge without a strobe, hit, miss, bus error and all selects are low, and every access yields exactly one of hit, miss or bus error.
- R11: On a hit, the index output carries the winning window number in binary, and select bit n is the only one set for window n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_addr | input | 32 | Access address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_win | input | 3 | Window number for configuration access |
| cfg_reg | input | 1 | 0 selects the base register, 1 the mask register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected register (combinational) |
| cs_sel | output | 6 | One-hot chip select, registered |
| hit_idx | output | 3 | Winning window number, registered |
| hit | output | 1 | Access selected a window |
| miss | output | 1 | Access matched no valid window |
| bus_err | output | 1 | Write to a protected window |

## Verification
The bench builds the decoder with its defaults: six windows, a 32-bit address and a 16-bit compared upper half. Six windows allow two overlapping valid windows, an invalid window that shadows the same base, and a protected window to coexist. With that setup, priority, masking, the valid gate and protection are all exercised against one another. A three-bit index also leaves window numbers 6 and 7 unused, so the configuration path for out-of-range indices is within reach.

// File: rtl/wsel_pkg.sv
package wsel_pkg;
   // Register select values on the configuration port
   typedef enum logic {
      REG_BASE = 1'b0,
      REG_MASK = 1'b1
   } wsel_reg_e;

   // Flag positions inside the mask register word
   localparam int unsigned FLAG_VALID_BIT = 0;
   localparam int unsigned FLAG_WP_BIT    = 8;
endpackage

// File: rtl/wsel_window.sv
module wsel_window #(
   parameter int unsigned AW   = 32,
   parameter int unsigned CMPW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_base,
   input  logic          we_mask,
   input  logic [AW-1:0] wdata,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] rd_base,
   output logic [AW-1:0] rd_mask,
   output logic          match,
   output logic          wprot
);
   import wsel_pkg::*;
   localparam int unsigned LOW = AW - CMPW;

   logic [CMPW-1:0] base_q;
   logic [CMPW-1:0] mask_q;
   logic            valid_q;
   logic            wp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         mask_q  <= '0;
         valid_q <= 1'b0;
         wp_q    <= 1'b0;
      end else begin
         if (we_base) base_q <= wdata[AW-1:LOW];
         if (we_mask) begin
            mask_q  <= wdata[AW-1:LOW];
            valid_q <= wdata[FLAG_VALID_BIT];
            wp_q    <= wdata[FLAG_WP_BIT];
         end
      end
   end

   always_comb begin
      rd_base = '0;
      rd_base[AW-1:LOW] = base_q;
      rd_mask = '0;
      rd_mask[AW-1:LOW] = mask_q;
      rd_mask[FLAG_WP_BIT] = wp_q;
      rd_mask[FLAG_VALID_BIT] = valid_q;
   end

   // Compared bits are those whose mask bit is clear
   logic [CMPW-1:0] diff;
   assign diff  = (addr[AW-1:LOW] ^ base_q) & ~mask_q;
   assign match = valid_q && (diff == '0);
   assign wprot = wp_q;

   a_r5_invalid_never_matches: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> !match);
endmodule

// File: rtl/wsel_prio.sv
module wsel_prio #(
   parameter int unsigned N    = 6,
   parameter int unsigned IDXW = 3
) (
   input  logic [N-1:0]    req,
   output logic [N-1:0]    grant,
   output logic [IDXW-1:0] idx,
   output logic            any
);
   // Scan from the top down so the lowest index is written last and wins
   always_comb begin
      grant = '0;
      idx   = '0;
      any   = |req;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IDXW'(i);
         end
      end
   end

   always_comb begin
      if (!$isunknown(req)) begin
         a_r6_single_grant: assert ($onehot0(grant) && (any == (grant != '0)));
      end
   end
endmodule

// File: rtl/wsel_top.sv
module wsel_top #(
   parameter int unsigned NWIN = 6,
   parameter int unsigned AW   = 32,
   parameter int unsigned CMPW = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_valid,
   input  logic                     acc_write,
   input  logic [AW-1:0]            acc_addr,
   input  logic                     cfg_we,
   input  logic [$clog2(NWIN)-1:0]  cfg_win,
   input  logic                     cfg_reg,
   input  logic [AW-1:0]            cfg_wdata,
   output logic [AW-1:0]            cfg_rdata,
   output logic [NWIN-1:0]          cs_sel,
   output logic [$clog2(NWIN)-1:0]  hit_idx,
   output logic                     hit,
   output logic                     miss,
   output logic                     bus_err
);
   import wsel_pkg::*;
   localparam int unsigned IDXW = $clog2(NWIN);
   localparam int unsigned LOW  = AW - CMPW;

   if (NWIN < 2) begin : g_chk_nwin
      $error("wsel_top: NWIN must be at least 2");
   end
   if (CMPW < 1 || CMPW >= AW) begin : g_chk_cmpw
      $error("wsel_top: CMPW must lie between 1 and AW-1");
   end
   if (LOW <= FLAG_WP_BIT) begin : g_chk_flags
      $error("wsel_top: flag bits must sit below the compared field");
   end

   logic [NWIN-1:0] win_match;
   logic [NWIN-1:0] win_wp;
   logic [AW-1:0]   rd_base_a [NWIN];
   logic [AW-1:0]   rd_mask_a [NWIN];

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      logic sel_here;
      assign sel_here = cfg_we && (cfg_win == IDXW'(g));
      wsel_window #(.AW(AW), .CMPW(CMPW)) u_win (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_base (sel_here && (cfg_reg == REG_BASE)),
         .we_mask (sel_here && (cfg_reg == REG_MASK)),
         .wdata   (cfg_wdata),
         .addr    (acc_addr),
         .rd_base (rd_base_a[g]),
         .rd_mask (rd_mask_a[g]),
         .match   (win_match[g]),
         .wprot   (win_wp[g])
      );
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (cfg_win == IDXW'(i))
            cfg_rdata = (cfg_reg == REG_MASK) ? rd_mask_a[i] : rd_base_a[i];
      end
   end

   logic [NWIN-1:0] grant;
   logic [IDXW-1:0] win_idx;
   logic            any_match;

   wsel_prio #(.N(NWIN), .IDXW(IDXW)) u_prio (
      .req   (win_match),
      .grant (grant),
      .idx   (win_idx),
      .any   (any_match)
   );

   logic prot_err;
   assign prot_err = any_match && acc_write && ((grant & win_wp) != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_sel  <= '0;
         hit_idx <= '0;
         hit     <= 1'b0;
         miss    <= 1'b0;
         bus_err <= 1'b0;
      end else if (acc_valid) begin
         cs_sel  <= (any_match && !prot_err) ? grant : '0;
         hit_idx <= win_idx;
         hit     <= any_match && !prot_err;
         miss    <= !any_match;
         bus_err <= prot_err;
      end else begin
         cs_sel  <= '0;
         hit_idx <= '0;
         hit     <= 1'b0;
         miss    <= 1'b0;
         bus_err <= 1'b0;
      end
   end

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !(hit || miss || bus_err) && (cs_sel == '0));
   a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> ($countones({hit, miss, bus_err}) == 1));
   a_r7_miss_no_select: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> (cs_sel == '0));
   a_r8_err_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> ($past(acc_write) && (cs_sel == '0)));
   a_r11_index_matches_select: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (cs_sel == (NWIN'(1) << hit_idx)));
endmodule

// File: tb/wsel_top_test.sv
module wsel_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_win = '0;
   logic        cfg_reg = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [5:0]  cs_sel;
   logic [2:0]  hit_idx;
   logic        hit, miss, bus_err;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   wsel_top uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_reg(cfg_reg),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cs_sel(cs_sel),
      .hit_idx(hit_idx), .hit(hit), .miss(miss), .bus_err(bus_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input int win, input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_win = 3'(win); cfg_reg = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_check(input string tag, input int win, input logic sel,
                            input logic [31:0] exp);
      @(negedge clk);
      cfg_win = 3'(win); cfg_reg = sel;
      #1;
      chk(tag, cfg_rdata, exp);
   endtask

   // Drives one access, checks its registered outcome, then the idle cycle after it
   task automatic access(input string tag, input logic [31:0] a, input logic wr,
                         input logic [5:0] exp_cs, input logic [2:0] exp_idx,
                         input logic exp_hit, input logic exp_miss, input logic exp_err);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = wr;
      @(negedge clk);
      acc_valid = 1'b0;
      chk({tag, " flags"}, {29'd0, hit, miss, bus_err}, {29'd0, exp_hit, exp_miss, exp_err});
      chk({tag, " select"}, {26'd0, cs_sel}, {26'd0, exp_cs});
      if (exp_hit) chk({tag, " index R11"}, {29'd0, hit_idx}, {29'd0, exp_idx});
      @(negedge clk);
      chk({tag, " idle after R10"}, {26'd0, cs_sel, hit, miss, bus_err}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R1 outputs in reset", {26'd0, cs_sel, hit, miss, bus_err}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      for (int w = 0; w < 6; w++) begin
         cfg_check("R1 base reset", w, 1'b0, 32'd0);
         cfg_check("R1 mask reset", w, 1'b1, 32'd0);
      end
      access("R1 access after reset misses", 32'h0000_0000, 1'b0, 6'd0, 3'd0, 0, 1, 0);
      access("R1 write after reset misses", 32'h1234_5678, 1'b1, 6'd0, 3'd0, 0, 1, 0);
   endtask

   task automatic t_regs;
      cfg_write(1, 1'b0, 32'hABCD_1234);
      cfg_check("R2 base low bits zero", 1, 1'b0, 32'hABCD_0000);
      cfg_write(1, 1'b1, 32'hFFFF_FFFF);
      cfg_check("R3 mask reserved bits zero", 1, 1'b1, 32'hFFFF_0101);
      cfg_write(1, 1'b1, 32'h0000_0000);
      cfg_check("R3 mask cleared", 1, 1'b1, 32'h0000_0000);
      cfg_write(7, 1'b0, 32'hFFFF_FFFF);
      for (int w = 0; w < 6; w++) cfg_check("R2 out-of-range index writes nothing", w, 1'b0,
                                            (w == 1) ? 32'hABCD_0000 : 32'd0);
   endtask

   task automatic t_mask;
      cfg_write(2, 1'b0, 32'h4000_0000);
      cfg_write(2, 1'b1, 32'h000F_0001);
      access("R4 masked bits ignored", 32'h4003_1234, 1'b0, 6'b000100, 3'd2, 1, 0, 0);
      access("R4 unmasked bit compared", 32'h4013_0000, 1'b0, 6'd0, 3'd0, 0, 1, 0);
      access("R4 low half ignored", 32'h4000_FFFF, 1'b1, 6'b000100, 3'd2, 1, 0, 0);
   endtask

   task automatic t_invalid;
      cfg_write(3, 1'b0, 32'h5000_0000);
      cfg_write(3, 1'b1, 32'hFFFF_0100);
      access("R5 invalid window ignored", 32'h5000_0000, 1'b0, 6'd0, 3'd0, 0, 1, 0);
      access("R7 no window matches", 32'h7777_0000, 1'b0, 6'd0, 3'd0, 0, 1, 0);
   endtask

   task automatic t_prio;
      cfg_write(4, 1'b0, 32'h4000_0000);
      cfg_write(4, 1'b1, 32'h00FF_0001);
      access("R6 lowest window wins", 32'h4003_0000, 1'b0, 6'b000100, 3'd2, 1, 0, 0);
      access("R6 upper window alone", 32'h4023_0000, 1'b0, 6'b010000, 3'd4, 1, 0, 0);
   endtask

   task automatic t_protect;
      cfg_write(5, 1'b0, 32'h6000_0000);
      cfg_write(5, 1'b1, 32'h0000_0101);
      access("R8 write to protected window", 32'h6000_0010, 1'b1, 6'd0, 3'd0, 0, 0, 1);
      access("R9 read of protected window", 32'h6000_0010, 1'b0, 6'b100000, 3'd5, 1, 0, 0);
      access("R8 write to unprotected window", 32'h4023_0000, 1'b1, 6'b010000, 3'd4, 1, 0, 0);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 32'h6000_0000;
      @(negedge clk);
      chk("R10 first of pair", {26'd0, cs_sel}, {26'd0, 6'b100000});
      acc_addr = 32'h9999_0000;
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R10 second of pair misses", {29'd0, hit, miss, bus_err}, 32'd2);
      @(negedge clk);
      chk("R10 quiet after pair", {26'd0, cs_sel, hit, miss, bus_err}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_regs();
      t_mask();
      t_invalid();
      t_prio();
      t_protect();
      t_back_to_back();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #400000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule